// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block sequences the operating mode of a small controller that has two oscillators: a fast main oscillator and a slow 32.768 kHz sub-oscillator. Software drives it with writes to a two-bit control word: a sub-oscillator enable and a slow-clock select. Two further pins request entry into an idle-type mode or a full stop, and one pin carries a wake-up event. Both clocks reach the block as single-cycle enable strobes (`fast_tick`, `slow_tick`) in one synchronous domain.

From these inputs the block sets the two oscillator enables and the system clock select. It also produces the halt signal for the CPU and the watchdog, and a flag that takes the sub-oscillator pins away from the general-purpose port logic. A machine-cycle strobe is derived by dividing the selected clock by four. Each idle-type mode remembers the clock domain it came from, and a wake-up returns to that domain.

A return to the fast clock, whether after slow operation or after a stop, waits for a programmable number of ticks so the restarted oscillator can settle. The warm-up count is taken from `warm_cnt`, and the ticks counted are those of the oscillator being restarted.

Top module: `pwrmode_ctl`

## Requirements
- R1: After reset the block is in single-clock mode with `mode` = 0. In that state `fast_osc_en`=1, `slow_osc_en`=0, `sel_slow`=0, `cpu_halt`=0, `err_sticky`=0 and `sub_pins_claimed`=0. The `mode` codes are: 0 single, 1 dual-fast, 2 slow, 3 idle from single, 4 idle from dual-fast, 5 sleep, 6 stop, 7 warm-up.
- R2: In single mode, a write with `cfg_osc_en`=1 moves the block to mode 1 on the next cycle. This raises `slow_osc_en` and `sub_pins_claimed`. In mode 1, a write with `cfg_osc_en`=0 and `cfg_sel_slow`=0 returns the block to mode 0, and both of those outputs fall.
- R3: A write with `cfg_sel_slow`=1 while the sub-oscillator enable is clear (mode 0) has no effect on the clock select. It sets `err_sticky`, which stays high until reset.
- R4: In mode 1, a write with `cfg_sel_slow`=1 enters mode 2. Mode 2 drives `fast_osc_en`=0 and `sel_slow`=1.
- R5: In mode 2, a write with `cfg_sel_slow`=0 enters mode 7. The fast oscillator is turned on, but `sel_slow` stays 1 and the CPU keeps running. After `warm_cnt` slow ticks the block enters mode 1 with `sel_slow`=0. Fast ticks do not advance this wait.
- R6: `req_idle` in mode 0 enters mode 3, and in mode 1 enters mode 4. Mode 4 keeps both oscillators on. Both of these modes raise `cpu_halt`. `wake` returns mode 3 to mode 0 and mode 4 to mode 1.
- R7: `req_idle` in mode 2 enters mode 5. Mode 5 has the fast oscillator off, the slow oscillator on and `cpu_halt`=1. `wake` returns it to mode 2.
- R8: `req_stop` enters mode 6, where both oscillators are off and `cpu_halt`=1. `wake` enters mode 7, which turns back on the oscillators of the mode that was left and keeps `cpu_halt` high. After `warm_cnt` ticks of that mode's clock (slow for mode 2, fast otherwise), the block resumes the mode that was left.
- R9: `mcyc_stb` is a one-cycle pulse in the cycle after every fourth tick of the selected, enabled clock. Ticks of the unselected clock have no effect on it.
- R10: While `cpu_halt` is high, the divider is held at zero and `mcyc_stb` is low from the second halted cycle on. After release, four fresh ticks are needed for the next pulse.
- R11: In the same cycle, `req_stop` takes priority over `req_idle`, which takes priority over a write. In modes 3 to 7, writes and requests are ignored; only `wake` (modes 3 to 6) and warm-up completion (mode 7) change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | One-cycle enable per fast oscillator period |
| slow_tick | input | 1 | One-cycle enable per sub-oscillator period |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_osc_en | input | 1 | Written sub-oscillator enable bit |
| cfg_sel_slow | input | 1 | Written slow-clock select bit |
| req_idle | input | 1 | Request entry into the idle-type mode of the current domain |
| req_stop | input | 1 | Request entry into full stop |
| wake | input | 1 | Wake-up event |
| warm_cnt | input | WARM_W | Oscillator warm-up length in ticks |
| fast_osc_en | output | 1 | Fast oscillator enable |
| slow_osc_en | output | 1 | Sub-oscillator enable |
| sel_slow | output | 1 | System clock select, 1 = slow clock |
| mcyc_stb | output | 1 | Machine-cycle strobe |
| cpu_halt | output | 1 | CPU halt |
| wdt_halt | output | 1 | Watchdog halt |
| sub_pins_claimed | output | 1 | Sub-oscillator pins removed from port use |
| err_sticky | output | 1 | Sticky refused-slow-request flag |
| mode | output | 3 | Current mode code (see R1) |

## Verification
The main function, mode sequencing, is exercised with several input patterns. Single writes and requests are applied in each of the running modes to show that every mode code has its own outputs. Simultaneous request-and-write patterns separate the priority order from mere acceptance. Wake-ups after stops from both the fast and the slow domain, with ticks of the wrong clock applied first, show whether the warm-up counts the restarted oscillator or simply any tick. For the divider, the tests apply tick bursts to the selected clock, bursts to the unselected clock, and a burst interrupted by an idle period; together these separate correct division from counting either clock and from a divider that keeps its count across a halt.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [2:0] {
    PM_SINGLE = 3'd0,
    PM_DUAL   = 3'd1,
    PM_SLOW   = 3'd2,
    PM_IDLE1  = 3'd3,
    PM_IDLE2  = 3'd4,
    PM_SLEEP  = 3'd5,
    PM_STOP   = 3'd6,
    PM_WARM   = 3'd7
  } pm_state_e;

  function automatic pm_state_e pm_idle_of(pm_state_e run);
    case (run)
      PM_SINGLE: return PM_IDLE1;
      PM_DUAL:   return PM_IDLE2;
      default:   return PM_SLEEP;
    endcase
  endfunction
endpackage

// File: rtl/pwr_warm_timer.sv
module pwr_warm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         tick,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= load;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_mcycle_gen.sv
module pwr_mcycle_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic stb
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb   <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (!run) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          stb   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwrmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  logic      cfg_osc_en,
  input  logic      cfg_sel_slow,
  input  logic      req_idle,
  input  logic      req_stop,
  input  logic      wake,
  input  logic      warm_done,
  output pm_state_e state,
  output logic      warm_start,
  output logic      warm_on_slow,
  output logic      fast_en,
  output logic      slow_en,
  output logic      sel_slow,
  output logic      halt,
  output logic      xten,
  output logic      err
);
  pm_state_e st_q, st_d, tgt_q, tgt_d;
  logic xten_q, xten_d, err_q, err_d;
  logic wstop_q, wstop_d, rslow_q, rslow_d;

  always_comb begin
    st_d       = st_q;
    tgt_d      = tgt_q;
    xten_d     = xten_q;
    err_d      = err_q;
    wstop_d    = wstop_q;
    rslow_d    = rslow_q;
    warm_start = 1'b0;
    case (st_q)
      PM_SINGLE, PM_DUAL, PM_SLOW: begin
        if (req_stop) begin
          st_d    = PM_STOP;
          tgt_d   = st_q;
          rslow_d = (st_q == PM_SLOW);
          wstop_d = 1'b1;
        end else if (req_idle) begin
          st_d = pm_idle_of(st_q);
        end else if (cfg_wr) begin
          case (st_q)
            PM_SINGLE: begin
              if (cfg_sel_slow) err_d = 1'b1;
              if (cfg_osc_en) begin
                xten_d = 1'b1;
                st_d   = PM_DUAL;
              end
            end
            PM_DUAL: begin
              if (cfg_sel_slow) begin
                st_d = PM_SLOW;
              end else if (!cfg_osc_en) begin
                xten_d = 1'b0;
                st_d   = PM_SINGLE;
              end
            end
            default: begin
              if (!cfg_sel_slow) begin
                st_d       = PM_WARM;
                tgt_d      = PM_DUAL;
                rslow_d    = 1'b1;
                wstop_d    = 1'b0;
                warm_start = 1'b1;
              end
            end
          endcase
        end
      end
      PM_IDLE1: if (wake) st_d = PM_SINGLE;
      PM_IDLE2: if (wake) st_d = PM_DUAL;
      PM_SLEEP: if (wake) st_d = PM_SLOW;
      PM_STOP: begin
        if (wake) begin
          st_d       = PM_WARM;
          warm_start = 1'b1;
        end
      end
      PM_WARM: if (warm_done) st_d = tgt_q;
      default: st_d = PM_SINGLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PM_SINGLE;
      tgt_q   <= PM_SINGLE;
      xten_q  <= 1'b0;
      err_q   <= 1'b0;
      wstop_q <= 1'b0;
      rslow_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      xten_q  <= xten_d;
      err_q   <= err_d;
      wstop_q <= wstop_d;
      rslow_q <= rslow_d;
    end
  end

  always_comb begin
    fast_en  = 1'b1;
    slow_en  = 1'b0;
    sel_slow = 1'b0;
    halt     = 1'b0;
    case (st_q)
      PM_SINGLE: ;
      PM_DUAL:  slow_en = 1'b1;
      PM_SLOW: begin
        fast_en  = 1'b0;
        slow_en  = 1'b1;
        sel_slow = 1'b1;
      end
      PM_IDLE1: halt = 1'b1;
      PM_IDLE2: begin
        slow_en = 1'b1;
        halt    = 1'b1;
      end
      PM_SLEEP: begin
        fast_en  = 1'b0;
        slow_en  = 1'b1;
        sel_slow = 1'b1;
        halt     = 1'b1;
      end
      PM_STOP: begin
        fast_en  = 1'b0;
        sel_slow = rslow_q;
        halt     = 1'b1;
      end
      default: begin
        fast_en  = (tgt_q != PM_SLOW);
        slow_en  = (tgt_q != PM_SINGLE);
        sel_slow = rslow_q;
        halt     = wstop_q;
      end
    endcase
  end

  assign state        = st_q;
  assign warm_on_slow = rslow_q;
  assign xten         = xten_q;
  assign err          = err_q;
endmodule

// File: rtl/pwrmode_ctl.sv
module pwrmode_ctl
  import pwrmode_pkg::*;
#(
  parameter int WARM_W = 8,
  parameter int MC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              cfg_wr,
  input  logic              cfg_osc_en,
  input  logic              cfg_sel_slow,
  input  logic              req_idle,
  input  logic              req_stop,
  input  logic              wake,
  input  logic [WARM_W-1:0] warm_cnt,
  output logic              fast_osc_en,
  output logic              slow_osc_en,
  output logic              sel_slow,
  output logic              mcyc_stb,
  output logic              cpu_halt,
  output logic              wdt_halt,
  output logic              sub_pins_claimed,
  output logic              err_sticky,
  output logic [2:0]        mode
);
  pm_state_e state;
  logic warm_start, warm_on_slow, warm_done, warm_tick;
  logic halt, xten, sys_tick;

  pwr_mode_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_osc_en   (cfg_osc_en),
    .cfg_sel_slow (cfg_sel_slow),
    .req_idle     (req_idle),
    .req_stop     (req_stop),
    .wake         (wake),
    .warm_done    (warm_done),
    .state        (state),
    .warm_start   (warm_start),
    .warm_on_slow (warm_on_slow),
    .fast_en      (fast_osc_en),
    .slow_en      (slow_osc_en),
    .sel_slow     (sel_slow),
    .halt         (halt),
    .xten         (xten),
    .err          (err_sticky)
  );

  assign warm_tick = warm_on_slow ? slow_tick : fast_tick;

  pwr_warm_timer #(.W(WARM_W)) i_warm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (warm_start),
    .load  (warm_cnt),
    .tick  (warm_tick),
    .done  (warm_done)
  );

  assign sys_tick = sel_slow ? (slow_tick & slow_osc_en) : (fast_tick & fast_osc_en);

  pwr_mcycle_gen #(.DIV(MC_DIV)) i_mcyc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sys_tick),
    .run   (!halt),
    .stb   (mcyc_stb)
  );

  assign cpu_halt         = halt;
  assign wdt_halt         = halt;
  assign sub_pins_claimed = xten;
  assign mode             = state;
endmodule

// File: rtl/pwrmode_ctl_chk.sv
module pwrmode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake,
  input logic       fast_osc_en,
  input logic       slow_osc_en,
  input logic       sel_slow,
  input logic       mcyc_stb,
  input logic       cpu_halt,
  input logic       sub_pins_claimed,
  input logic       err_sticky,
  input logic [2:0] mode
);
  AST_SINGLE_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> (!slow_osc_en && !sub_pins_claimed)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R3
  AST_SLOW_NO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (!fast_osc_en && sel_slow)); // R4
  AST_SWITCH_KEEPS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd7) && !cpu_halt) |-> (sel_slow && fast_osc_en)); // R5
  AST_IDLE2_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd4) && wake) |=> (mode == 3'd1)); // R6
  AST_SLEEP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd5) && wake) |=> (mode == 3'd2)); // R7
  AST_STOP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6) |-> (!fast_osc_en && !slow_osc_en && cpu_halt)); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mcyc_stb |=> !mcyc_stb); // R9
  AST_NO_HALTED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_halt) && cpu_halt) |-> !mcyc_stb); // R10
endmodule

bind pwrmode_ctl pwrmode_ctl_chk i_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wake             (wake),
  .fast_osc_en      (fast_osc_en),
  .slow_osc_en      (slow_osc_en),
  .sel_slow         (sel_slow),
  .mcyc_stb         (mcyc_stb),
  .cpu_halt         (cpu_halt),
  .sub_pins_claimed (sub_pins_claimed),
  .err_sticky       (err_sticky),
  .mode             (mode)
);

// File: tb/test_pwrmode_ctl.sv
`timescale 1ns/1ps
module test_pwrmode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_tick = 0, slow_tick = 0, cfg_wr = 0, cfg_osc_en = 0, cfg_sel_slow = 0;
  logic req_idle = 0, req_stop = 0, wake = 0;
  logic [7:0] warm_cnt = 8'd3;
  logic fast_osc_en, slow_osc_en, sel_slow, mcyc_stb, cpu_halt, wdt_halt;
  logic sub_pins_claimed, err_sticky;
  logic [2:0] mode;
  int tests = 0, fails = 0, stb_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwrmode_ctl i_pwrmode_ctl (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .cfg_wr(cfg_wr), .cfg_osc_en(cfg_osc_en), .cfg_sel_slow(cfg_sel_slow),
    .req_idle(req_idle), .req_stop(req_stop), .wake(wake), .warm_cnt(warm_cnt),
    .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en), .sel_slow(sel_slow),
    .mcyc_stb(mcyc_stb), .cpu_halt(cpu_halt), .wdt_halt(wdt_halt),
    .sub_pins_claimed(sub_pins_claimed), .err_sticky(err_sticky), .mode(mode)
  );

  always @(posedge clk) if (rst_n && mcyc_stb) stb_cnt++;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic wr(logic osc, logic sel);
    cfg_wr = 1; cfg_osc_en = osc; cfg_sel_slow = sel;
    cyc(1);
    cfg_wr = 0; cfg_osc_en = 0; cfg_sel_slow = 0;
  endtask

  task automatic pulse_idle();  req_idle = 1; cyc(1); req_idle = 0; endtask
  task automatic pulse_stop();  req_stop = 1; cyc(1); req_stop = 0; endtask
  task automatic pulse_wake();  wake = 1; cyc(1); wake = 0; endtask

  task automatic fast_pulses(int n);
    for (int i = 0; i < n; i++) begin
      fast_tick = 1; cyc(1); fast_tick = 0; cyc(1);
    end
  endtask

  task automatic slow_pulses(int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1; cyc(1); slow_tick = 0; cyc(1);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 mode", mode, 0);
    chk("R1 fast_osc_en", fast_osc_en, 1);
    chk("R1 slow_osc_en", slow_osc_en, 0);
    chk("R1 sel_slow", sel_slow, 0);
    chk("R1 halts", {cpu_halt, wdt_halt}, 0);
    chk("R1 err/pins", {err_sticky, sub_pins_claimed}, 0);
  endtask

  task automatic t_single_dual();
    do_reset();
    wr(1, 0);
    chk("R2 enter dual mode", mode, 1);
    chk("R2 slow osc on", slow_osc_en, 1);
    chk("R2 pins claimed", sub_pins_claimed, 1);
    wr(0, 0);
    chk("R2 back to single", mode, 0);
    chk("R2 slow osc off", slow_osc_en, 0);
    chk("R2 pins released", sub_pins_claimed, 0);
  endtask

  task automatic t_refuse_slow();
    do_reset();
    wr(0, 1);
    chk("R3 refused mode", mode, 0);
    chk("R3 sel unchanged", sel_slow, 0);
    chk("R3 err set", err_sticky, 1);
    wr(1, 0);
    cyc(2);
    chk("R3 err sticky", err_sticky, 1);
    do_reset();
    chk("R3 err cleared by reset", err_sticky, 0);
  endtask

  task automatic t_enter_slow();
    do_reset();
    wr(1, 0);
    wr(1, 1);
    chk("R4 slow mode", mode, 2);
    chk("R4 fast off", fast_osc_en, 0);
    chk("R4 sel slow", sel_slow, 1);
  endtask

  task automatic t_switch_back();
    warm_cnt = 8'd3;
    do_reset();
    wr(1, 0);
    wr(1, 1);
    wr(1, 0);
    chk("R5 warm mode", mode, 7);
    chk("R5 fast on", fast_osc_en, 1);
    chk("R5 sel still slow", sel_slow, 1);
    chk("R5 cpu runs", cpu_halt, 0);
    fast_pulses(5);
    chk("R5 fast ticks ignored", mode, 7);
    slow_pulses(2);
    chk("R5 two ticks short", mode, 7);
    slow_pulses(1);
    chk("R5 dual after warm", mode, 1);
    chk("R5 sel fast", sel_slow, 0);
  endtask

  task automatic t_idle();
    do_reset();
    pulse_idle();
    chk("R6 idle from single", mode, 3);
    chk("R6 halted", {cpu_halt, wdt_halt}, 3);
    pulse_wake();
    chk("R6 wake to single", mode, 0);
    wr(1, 0);
    pulse_idle();
    chk("R6 idle from dual", mode, 4);
    chk("R6 both osc on", {fast_osc_en, slow_osc_en}, 3);
    pulse_wake();
    chk("R6 wake to dual", mode, 1);
    chk("R6 released", cpu_halt, 0);
  endtask

  task automatic t_sleep();
    do_reset();
    wr(1, 0);
    wr(1, 1);
    pulse_idle();
    chk("R7 sleep", mode, 5);
    chk("R7 osc fast off slow on", {fast_osc_en, slow_osc_en}, 1);
    chk("R7 halted", cpu_halt, 1);
    pulse_wake();
    chk("R7 wake to slow", mode, 2);
  endtask

  task automatic t_stop();
    warm_cnt = 8'd2;
    do_reset();
    wr(1, 0);
    pulse_stop();
    chk("R8 stop", mode, 6);
    chk("R8 osc off", {fast_osc_en, slow_osc_en}, 0);
    chk("R8 halted", cpu_halt, 1);
    pulse_wake();
    chk("R8 warm after stop", mode, 7);
    chk("R8 osc restarted", {fast_osc_en, slow_osc_en}, 3);
    chk("R8 halt held", cpu_halt, 1);
    slow_pulses(3);
    chk("R8 slow ticks ignored", mode, 7);
    fast_pulses(1);
    chk("R8 one tick short", mode, 7);
    fast_pulses(1);
    chk("R8 resume dual", mode, 1);
    chk("R8 halt released", cpu_halt, 0);
    warm_cnt = 8'd1;
    wr(1, 1);
    pulse_stop();
    pulse_wake();
    chk("R8 slow warm osc", {fast_osc_en, slow_osc_en, sel_slow}, 3);
    fast_pulses(2);
    chk("R8 fast ticks ignored", mode, 7);
    slow_pulses(1);
    chk("R8 resume slow", mode, 2);
  endtask

  task automatic t_strobe();
    int s0;
    do_reset();
    s0 = stb_cnt;
    fast_pulses(3);
    chk("R9 no strobe after three", stb_cnt - s0, 0);
    fast_tick = 1; cyc(1); fast_tick = 0;
    chk("R9 strobe after fourth", mcyc_stb, 1);
    cyc(1);
    chk("R9 one cycle wide", mcyc_stb, 0);
    s0 = stb_cnt;
    slow_pulses(8);
    chk("R9 unselected ignored", stb_cnt - s0, 0);
    fast_pulses(8);
    chk("R9 eight ticks two strobes", stb_cnt - s0, 2);
  endtask

  task automatic t_halt_strobe();
    int s0;
    do_reset();
    fast_pulses(3);
    pulse_idle();
    s0 = stb_cnt;
    fast_pulses(8);
    chk("R10 none while halted", stb_cnt - s0, 0);
    pulse_wake();
    fast_pulses(1);
    chk("R10 divider cleared", stb_cnt - s0, 0);
    fast_pulses(3);
    chk("R10 four fresh ticks", stb_cnt - s0, 1);
  endtask

  task automatic t_priority();
    do_reset();
    wr(1, 0);
    req_stop = 1; req_idle = 1; cfg_wr = 1; cfg_sel_slow = 1;
    cyc(1);
    req_stop = 0; req_idle = 0; cfg_wr = 0; cfg_sel_slow = 0;
    chk("R11 stop wins", mode, 6);
    pulse_idle();
    wr(0, 0);
    chk("R11 ignored in stop", mode, 6);
    do_reset();
    wr(1, 0);
    req_idle = 1; cfg_wr = 1; cfg_osc_en = 1; cfg_sel_slow = 1;
    cyc(1);
    req_idle = 0; cfg_wr = 0; cfg_osc_en = 0; cfg_sel_slow = 0;
    chk("R11 idle beats write", mode, 4);
    wr(1, 1);
    chk("R11 write ignored in idle", {mode, fast_osc_en}, {3'd4, 1'b1});
    pulse_wake();
    chk("R11 wake to dual", mode, 1);
  endtask

  initial begin
    t_reset_state();
    t_single_dual();
    t_refuse_slow();
    t_enter_slow();
    t_switch_back();
    t_idle();
    t_sleep();
    t_stop();
    t_strobe();
    t_halt_strobe();
    t_priority();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end
endmodule